// File: doc/BRIEF.md
# Indirect Register Access Port

This block puts a bank of up to 64 internal byte registers behind one byte-wide host address. The host alternates between two kinds of access on that address: a pointer access, which selects an internal register number, and a data access, which writes or reads the selected register. A three-state machine keeps track of which kind of access comes next. It drives the write strobe, read strobe, address and write data of an external register file, and it selects the byte returned to the host.

The block also holds the master interrupt control register at internal number 0. Bit 0 of that register is a device reset. While it is set, the block raises a reset output for the register file, stays in a reset state and ignores every write whose bit 0 is set. A fixed six-access host sequence brings the interface back to the pointer state from any state it may be in: read, write 0x00, read, write 0x00, write 0x01, write 0x00. The sequence passes through device reset on the way.

Top module: `irp_port`

## Requirements
- R1: When a host write in the pointer state is followed by a host write in the data state, the second write raises reg_we_o for exactly that one cycle. During that cycle reg_addr_o holds the register number from the first write and reg_wdata_o holds the second byte. This applies to register numbers 1 to NUM_REGS-1.
- R2: When a host write of a register number is followed by a host read, host_rdata_o holds that register's byte from the clock edge of the read onward. reg_re_o is high during the read cycle for numbers 1 to NUM_REGS-1.
- R3: After any data-state read or write, the interface is back in the pointer state, so the next host write is taken as a register number.
- R4: A host read in the pointer state returns the pointer-state flag 0x80 and leaves the interface in the pointer state.
- R5: A pointer write uses only bits 5:0 as the register number and ignores bits 7:6.
- R6: Register numbers from NUM_REGS to 63 read as 0x00. A data write to one of them raises no reg_we_o.
- R7: A data write to register 0 with bit 0 set enters the reset state: dev_reset_o goes high and register 0 becomes 0x01. In the reset state, a write with bit 0 set keeps the reset state and raises no reg_we_o, and a host read returns 0x01.
- R8: In the reset state, a host write with bit 0 clear leaves reset: dev_reset_o goes low, register 0 becomes 0x00 and the interface enters the pointer state.
- R9: The six-access recovery sequence raises dev_reset_o at least once and ends in the pointer state, whatever the starting state. Registers written before the sequence read 0x00 afterwards.
- R10: After rst_ni is released, the interface is in the reset state with dev_reset_o high and host_rdata_o at 0x00. Once reset is cleared, register 0 reads 0x00.
- R11: A cycle with both host_rd_i and host_wr_i high is handled as a read only, and the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_rd_i | input | 1 | Host read strobe, one cycle per access |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Byte returned by the last host read |
| reg_we_o | output | 1 | Register file write strobe |
| reg_re_o | output | 1 | Register file read strobe |
| reg_addr_o | output | 6 | Selected register number |
| reg_wdata_o | output | 8 | Register file write byte |
| reg_rdata_i | input | 8 | Register file byte at reg_addr_o |
| dev_reset_o | output | 1 | Device reset to the register file, high in the reset state |

## Verification
If the state machine is in the wrong state, the next host access shows it at once. A read that should return the 0x80 flag returns a register byte instead, or a byte meant as data shows up on reg_addr_o as a register number. A wrong pointer shows on reg_addr_o in the cycle of the data access. A mishandled reset bit shows in two ways: dev_reset_o stays high or low when it should not, and a pulse on reg_we_o appears while in reset. The bench sweeps every register number and runs the recovery sequence from each of the three states, so any of these faults shows up within one or two host accesses.

// File: rtl/irp_pkg.sv
package irp_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_PTR   = 2'd1,
    ST_DATA  = 2'd2
  } irp_state_e;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PTR_WR  = 3'd1,
    OP_PTR_RD  = 3'd2,
    OP_DATA_WR = 3'd3,
    OP_DATA_RD = 3'd4,
    OP_RST_WR  = 3'd5,
    OP_RST_RD  = 3'd6
  } irp_op_e;

  localparam logic [7:0] PTR_FLAG = 8'h80;
  localparam logic [7:0] MIC_IN_RESET = 8'h01;
endpackage

// File: rtl/irp_fsm.sv
module irp_fsm
  import irp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic       wbit0_i,
  input  logic       ptr_zero_i,
  output irp_op_e    op_o,
  output irp_state_e state_o
);
  irp_state_e state_q, state_d;

  // read wins over write in the same cycle
  always_comb begin
    op_o = OP_NONE;
    if (rd_i) begin
      unique case (state_q)
        ST_RESET: op_o = OP_RST_RD;
        ST_PTR:   op_o = OP_PTR_RD;
        ST_DATA:  op_o = OP_DATA_RD;
        default:  op_o = OP_PTR_RD;
      endcase
    end else if (wr_i) begin
      unique case (state_q)
        ST_RESET: op_o = OP_RST_WR;
        ST_PTR:   op_o = OP_PTR_WR;
        ST_DATA:  op_o = OP_DATA_WR;
        default:  op_o = OP_NONE;
      endcase
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (op_o)
      OP_RST_WR:  state_d = wbit0_i ? ST_RESET : ST_PTR;
      OP_PTR_WR:  state_d = ST_DATA;
      OP_PTR_RD:  state_d = ST_PTR;
      OP_DATA_RD: state_d = ST_PTR;
      OP_DATA_WR: state_d = (ptr_zero_i && wbit0_i) ? ST_RESET : ST_PTR;
      default:    state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/irp_ptr.sv
module irp_ptr
  import irp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  irp_op_e           op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  // upper bits of the pointer byte are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ptr_q <= '0;
    else if (op_i == OP_PTR_WR) ptr_q <= wdata_i[ADDR_W-1:0];
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/irp_mic.sv
module irp_mic
  import irp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  irp_op_e           op_i,
  input  logic              ptr_zero_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mic_o
);
  localparam logic [DATA_W-1:0] IN_RESET = DATA_W'(MIC_IN_RESET);
  logic [DATA_W-1:0] mic_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mic_q <= IN_RESET;
    end else begin
      if (op_i == OP_DATA_WR && ptr_zero_i) begin
        mic_q <= wdata_i[0] ? IN_RESET : wdata_i;
      end else if (op_i == OP_RST_WR && !wdata_i[0]) begin
        mic_q <= '0;
      end
    end
  end

  assign mic_o = mic_q;
endmodule

// File: rtl/irp_rdmux.sv
module irp_rdmux
  import irp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  irp_op_e           op_i,
  input  logic              ptr_zero_i,
  input  logic              ptr_impl_i,
  input  logic [DATA_W-1:0] mic_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q, sel;
  logic              take;

  always_comb begin
    take = 1'b1;
    sel  = '0;
    unique case (op_i)
      OP_PTR_RD:  sel = DATA_W'(PTR_FLAG);
      OP_RST_RD:  sel = mic_i;
      OP_DATA_RD: sel = ptr_zero_i ? mic_i : (ptr_impl_i ? reg_rdata_i : '0);
      default:    take = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (take) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irp_port.sv
module irp_port
  import irp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 6,
  parameter int NUM_REGS = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              dev_reset_o
);
  localparam logic [ADDR_W:0] IMPL_LIMIT = (ADDR_W+1)'(NUM_REGS);

  irp_op_e           op;
  irp_state_e        state;
  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] mic;
  logic              ptr_zero, ptr_impl;

  assign ptr_zero = (ptr == '0);
  assign ptr_impl = !ptr_zero && ({1'b0, ptr} < IMPL_LIMIT);

  irp_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (host_rd_i),
    .wr_i       (host_wr_i),
    .wbit0_i    (host_wdata_i[0]),
    .ptr_zero_i (ptr_zero),
    .op_o       (op),
    .state_o    (state)
  );

  irp_ptr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .wdata_i (host_wdata_i),
    .ptr_o   (ptr)
  );

  irp_mic #(.DATA_W(DATA_W)) u_mic (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (op),
    .ptr_zero_i (ptr_zero),
    .wdata_i    (host_wdata_i),
    .mic_o      (mic)
  );

  irp_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .ptr_zero_i  (ptr_zero),
    .ptr_impl_i  (ptr_impl),
    .mic_i       (mic),
    .reg_rdata_i (reg_rdata_i),
    .rdata_o     (host_rdata_o)
  );

  assign reg_we_o    = (op == OP_DATA_WR) && ptr_impl;
  assign reg_re_o    = (op == OP_DATA_RD) && ptr_impl;
  assign reg_addr_o  = ptr;
  assign reg_wdata_o = host_wdata_i;
  assign dev_reset_o = (state == ST_RESET);
endmodule

// File: rtl/irp_port_chk.sv
module irp_port_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_rd_i,
  input logic              host_wr_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic              reg_we_o,
  input logic              reg_re_o,
  input logic              dev_reset_o
);
  AST_NO_WE_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_reset_o |-> !reg_we_o); // R7

  AST_RESET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_reset_o && host_wr_i && !host_rd_i && host_wdata_i[0]) |=> dev_reset_o); // R7

  AST_RESET_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_reset_o && host_wr_i && !host_rd_i && !host_wdata_i[0]) |=> !dev_reset_o); // R8

  AST_BACK_TO_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |=> !(reg_we_o || reg_re_o)); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_re_o})); // R11

  AST_WE_NEEDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (host_wr_i && !host_rd_i)); // R1
endmodule

bind irp_port irp_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_rd_i    (host_rd_i),
  .host_wr_i    (host_wr_i),
  .host_wdata_i (host_wdata_i),
  .reg_we_o     (reg_we_o),
  .reg_re_o     (reg_re_o),
  .dev_reset_o  (dev_reset_o)
);

// File: tb/irp_port_bench.sv
`timescale 1ns/1ps
module irp_port_bench;
  localparam int NREG = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       reg_we, reg_re, dev_reset;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] mem [64];
  int checks = 0, errors = 0, we_count = 0, re_count = 0;
  bit reset_seen = 0, done = 0;

  always #5 clk = ~clk;

  irp_port #(.NUM_REGS(NREG)) u_irp_port (
    .clk_i(clk), .rst_ni(rst_n), .host_rd_i(host_rd), .host_wr_i(host_wr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .reg_we_o(reg_we),
    .reg_re_o(reg_re), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_rdata_i(reg_rdata), .dev_reset_o(dev_reset)
  );

  // register file model
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (dev_reset) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
      reset_seen <= 1'b1;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
    if (reg_we) we_count <= we_count + 1;
    if (reg_re) re_count <= re_count + 1;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 5) & 8'h7f);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); host_wr = 1'b1; host_wdata = v;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; v = host_rdata;
  endtask

  task automatic recover();
    logic [7:0] d;
    rd(d); wr(8'h00); rd(d); wr(8'h00); wr(8'h01); wr(8'h00);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int wc, rc;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 dev_reset after rst", {7'b0, dev_reset}, 8'h01);
    chk("R10 rdata after rst", host_rdata, 8'h00);
    rd(v); chk("R7 read in reset", v, 8'h01);
    wr(8'h00);
    chk("R8 reset cleared", {7'b0, dev_reset}, 8'h00);
    rd(v); chk("R4 pointer flag", v, 8'h80);
    rd(v); chk("R4 stays pointer", v, 8'h80);
    wr(8'h00); rd(v); chk("R10 mic reads 0", v, 8'h00);

    // full sweep of register numbers
    for (int a = 1; a < 64; a++) begin
      wc = we_count;
      wr(8'(a)); wr(pat(a));
      chk(a < NREG ? "R1 write strobe count" : "R6 no write strobe",
          8'(we_count - wc), a < NREG ? 8'h01 : 8'h00);
    end
    for (int a = 1; a < 64; a++) begin
      rc = re_count;
      wr(8'(a)); rd(v);
      chk(a < NREG ? "R2 readback" : "R6 unimplemented reads 0", v, a < NREG ? pat(a) : 8'h00);
      chk("R2 read strobe", 8'(re_count - rc), a < NREG ? 8'h01 : 8'h00);
      rd(v); chk("R3 back to pointer", v, 8'h80);
    end

    // upper pointer bits ignored
    for (int hi = 1; hi < 4; hi++) begin
      wr(8'((hi << 6) | 7)); rd(v); chk("R5 upper bits ignored", v, pat(7));
      wr(8'((hi << 6) | 9)); wr(8'h3c);
      wr(8'h09); rd(v); chk("R5 write through high ptr", v, 8'h3c);
      wr(8'h09); wr(pat(9));
    end

    // mic holds non-reset bits
    wr(8'h00); wr(8'h5a); wr(8'h00); rd(v); chk("R3 mic data write", v, 8'h5a);
    chk("R7 no reset on bit0 clear", {7'b0, dev_reset}, 8'h00);

    // simultaneous rd and wr in pointer state
    @(negedge clk); host_rd = 1'b1; host_wr = 1'b1; host_wdata = 8'h05;
    @(negedge clk); host_rd = 1'b0; host_wr = 1'b0;
    chk("R11 both strobes read", host_rdata, 8'h80);
    rd(v); chk("R11 write ignored", v, 8'h80);

    // enter reset and try writes with bit0 set
    wr(8'h00); wr(8'hff);
    chk("R7 reset entered", {7'b0, dev_reset}, 8'h01);
    wc = we_count;
    wr(8'h03); wr(8'h21);
    chk("R7 held in reset", {7'b0, dev_reset}, 8'h01);
    chk("R7 writes ignored", 8'(we_count - wc), 8'h00);
    rd(v); chk("R7 mic in reset", v, 8'h01);
    wr(8'hfe);
    chk("R8 reset exit", {7'b0, dev_reset}, 8'h00);
    wr(8'h00); rd(v); chk("R8 mic cleared", v, 8'h00);
    rd(v); chk("R8 pointer state", v, 8'h80);

    // recovery from each of the three states
    for (int s = 0; s < 3; s++) begin
      wr(8'h04); wr(pat(4));
      if (s == 0) begin wr(8'h00); wr(8'h01); end
      if (s == 2) wr(8'h04);
      @(negedge clk); reset_seen = 1'b0;
      recover();
      chk("R9 reset pulse seen", {7'b0, reset_seen}, 8'h01);
      chk("R9 reset released", {7'b0, dev_reset}, 8'h00);
      rd(v); chk("R9 ends in pointer state", v, 8'h80);
      wr(8'h04); rd(v); chk("R9 device registers cleared", v, 8'h00);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule